// File: doc/BRIEF.md
# Ethernet PHY Port Control Word

This block keeps the basic control word of one Ethernet PHY port and applies its mode bits to the media-independent data path. A management front end that has already decoded the serial frame presents a one-cycle write strobe with sixteen bits of data, and reads the stored word back at any time. The block works out the effective link speed and duplex, and it switches the port between normal operation, digital loopback, isolation and power-down.

A write with the top bit set starts a timed soft reset. During the reset the word holds its defaults and the top bit reads back as 1. When the reset counter expires, the bit clears itself and a short management-busy window opens, in which the frame decoder must not accept a new start of frame. Leaving isolation or power-down starts a wake-up counter. A not-ready flag holds the data path off until that counter finishes.

On the MAC side, the transmit inputs are forwarded to the line only in normal operation. The receive, collision and carrier outputs are fed from the line, or from the looped transmit signals in loopback, or they are held at zero. A separate output enable lets the pad ring place the receive-side and clock outputs in high impedance while the port is isolated.

Top module: `phy_port_ctrl`

## Requirements
- R1: After a hardware reset the word reads 0x3000: auto-negotiation enable (bit 12) and speed (bit 13) are 1, and loopback (bit 14), power-down (bit 11), isolate (bit 10), duplex (bit 8) and reset (bit 15) are 0. Bits 9 and 7..0 always read 0.
- R2: A write with bit 15 = 0 stores bits 14..8 as given. A write with bit 15 = 1 starts a soft reset and stores the defaults, and every other written bit is discarded. Any write that lands while a reset is running, including its last cycle, is ignored.
- R3: After the write edge that starts a soft reset, bit 15 reads 1 for exactly RST_CYCLES cycles and then reads 0. mgmt_busy is 1 for exactly BUSY_CYCLES cycles after that, and it is 0 at all other times.
- R4: When auto-negotiation enable is 0, link_speed_100 follows bit 13 (1 = 100 Mbps) and link_full_duplex follows bit 8. When it is 1, both outputs follow an_speed_100 and an_full_duplex, while bits 13 and 8 stay readable and writable.
- R5: With loopback set, the MAC transmit enable, error and data appear on mac_rx_dv, mac_rx_er and mac_rxd one cycle later, and mac_crs follows the looped transmit enable. The line transmit outputs stay 0, the line receive inputs are ignored, and mac_col stays 0.
- R6: With isolate set, mac_out_oe is 0, the MAC transmit inputs do not reach the line, and the MAC receive outputs are 0. Management reads and writes still work.
- R7: With power-down set, the line transmit outputs and MAC receive outputs are 0 while mac_out_oe stays 1. The stored bits are kept, and operation resumes from them.
- R8: When power-down and isolate are both 0 again, not_ready is 1 for exactly WAKE_CYCLES cycles after the write edge that cleared them, and the data path stays off during that window.
- R9: In normal operation the MAC transmit signals reach the line outputs and the line receive, collision and carrier inputs reach the MAC outputs with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mgmt_wr_en | input | 1 | One-cycle write strobe from the management decoder |
| mgmt_wr_data | input | 16 | Control word to write |
| mgmt_rd_data | output | 16 | Stored control word |
| mgmt_busy | output | 1 | Start of frame must not be accepted |
| an_speed_100 | input | 1 | Negotiated speed, 1 = 100 Mbps |
| an_full_duplex | input | 1 | Negotiated duplex, 1 = full |
| link_speed_100 | output | 1 | Effective speed |
| link_full_duplex | output | 1 | Effective duplex |
| loopback_on | output | 1 | Loopback bit in force |
| powered_down | output | 1 | Power-down bit in force |
| isolated | output | 1 | Isolate bit in force |
| not_ready | output | 1 | Wake-up window running |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_tx_er | input | 1 | MAC transmit error |
| mac_txd | input | 4 | MAC transmit data |
| line_tx_en | output | 1 | Transmit enable toward the medium |
| line_tx_er | output | 1 | Transmit error toward the medium |
| line_txd | output | 4 | Transmit data toward the medium |
| line_rx_dv | input | 1 | Receive data valid from the medium |
| line_rx_er | input | 1 | Receive error from the medium |
| line_rxd | input | 4 | Receive data from the medium |
| line_crs | input | 1 | Carrier sense from the medium |
| line_col | input | 1 | Collision from the medium |
| mac_rx_dv | output | 1 | Receive data valid to the MAC |
| mac_rx_er | output | 1 | Receive error to the MAC |
| mac_rxd | output | 4 | Receive data to the MAC |
| mac_crs | output | 1 | Carrier sense to the MAC |
| mac_col | output | 1 | Collision to the MAC |
| mac_out_oe | output | 1 | Output enable for receive-side and clock pads |

## Verification
The end of a soft reset and a management write can fall in the same cycle. The bench places a write carrying new bits exactly on the last edge of the reset count. It expects the word to read the defaults with bit 15 clear and mgmt_busy raised, so the write is judged as ignored. A second write one cycle later, inside the busy window, must be stored, which shows that the busy flag guards only frame starts and does not guard register writes.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

  localparam int WORD_W     = 16;
  localparam int B_RESET    = 15;
  localparam int B_LOOP     = 14;
  localparam int B_SPEED    = 13;
  localparam int B_ANEN     = 12;
  localparam int B_PDWN     = 11;
  localparam int B_ISO      = 10;
  localparam int B_DUPLEX   = 8;

  typedef struct packed {
    logic loop;
    logic speed;
    logic an_en;
    logic pdwn;
    logic iso;
    logic duplex;
  } ctrl_t;

  localparam ctrl_t CTRL_DEFAULT = '{loop: 1'b0, speed: 1'b1, an_en: 1'b1,
                                     pdwn: 1'b0, iso: 1'b0, duplex: 1'b0};

  function automatic ctrl_t word_to_ctrl(input logic [WORD_W-1:0] w);
    ctrl_t c;
    c.loop   = w[B_LOOP];
    c.speed  = w[B_SPEED];
    c.an_en  = w[B_ANEN];
    c.pdwn   = w[B_PDWN];
    c.iso    = w[B_ISO];
    c.duplex = w[B_DUPLEX];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c, input logic rst);
    logic [WORD_W-1:0] w;
    w           = '0;
    w[B_RESET]  = rst;
    w[B_LOOP]   = c.loop;
    w[B_SPEED]  = c.speed;
    w[B_ANEN]   = c.an_en;
    w[B_PDWN]   = c.pdwn;
    w[B_ISO]    = c.iso;
    w[B_DUPLEX] = c.duplex;
    return w;
  endfunction

endpackage

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phy_ctl_pkg::*;
#(
  parameter int RST_CYCLES  = 32500,
  parameter int BUSY_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic              rst_active,
  output logic              mgmt_busy
);

  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  ctrl_t         ctrl_q, ctrl_d;
  logic          act_q, act_d;
  logic [RW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] busy_q, busy_d;
  logic          upd_en;
  logic          unused_wbits;

  assign unused_wbits = ^{wr_data[9], wr_data[7:0]};

  always_comb begin
    ctrl_d = ctrl_q;
    act_d  = act_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q != '0) busy_d = busy_q - 1'b1;
    if (act_q) begin
      ctrl_d = CTRL_DEFAULT;
      if (cnt_q == '0) begin
        act_d  = 1'b0;
        busy_d = BW'(BUSY_CYCLES);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (wr_en) begin
      if (wr_data[B_RESET]) begin
        act_d  = 1'b1;
        cnt_d  = RW'(RST_CYCLES - 1);
        ctrl_d = CTRL_DEFAULT;
      end else begin
        ctrl_d = word_to_ctrl(wr_data);
      end
    end
  end

  assign upd_en = act_q | wr_en | (busy_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEFAULT;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      busy_q <= '0;
    end else if (upd_en) begin
      ctrl_q <= ctrl_d;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign ctrl       = ctrl_q;
  assign rst_active = act_q;
  assign mgmt_busy  = (busy_q != '0);

  // R2: defaults are held for the whole reset sequence
  a_r2_defaults_held: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (ctrl_q == CTRL_DEFAULT));

  // R3: the busy window opens as the reset bit clears
  a_r3_busy_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> mgmt_busy);

  // R3: busy never starts without a reset finishing
  a_r3_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mgmt_busy) |-> $past(act_q));

endmodule

// File: rtl/phy_ctl_wake.sv
module phy_ctl_wake #(
  parameter int WAKE_CYCLES = 12500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic not_ready
);

  localparam int WW = $clog2(WAKE_CYCLES + 1);

  logic [WW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (sleep)             cnt_d = WW'(WAKE_CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en = sleep | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign not_ready = (cnt_q != '0);

  // R8: leaving sleep always opens the wake-up window
  a_r8_wake_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> not_ready);

  // R8: while asleep the window is armed
  a_r8_armed_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> not_ready);

endmodule

// File: rtl/phy_ctl_datapath.sv
module phy_ctl_datapath #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loop,
  input  logic          iso,
  input  logic          path_on,
  input  logic          mac_tx_en,
  input  logic          mac_tx_er,
  input  logic [DW-1:0] mac_txd,
  output logic          line_tx_en,
  output logic          line_tx_er,
  output logic [DW-1:0] line_txd,
  input  logic          line_rx_dv,
  input  logic          line_rx_er,
  input  logic [DW-1:0] line_rxd,
  input  logic          line_crs,
  input  logic          line_col,
  output logic          mac_rx_dv,
  output logic          mac_rx_er,
  output logic [DW-1:0] mac_rxd,
  output logic          mac_crs,
  output logic          mac_col,
  output logic          mac_out_oe
);

  logic          lb_en_q, lb_er_q;
  logic [DW-1:0] lb_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_en_q <= 1'b0;
      lb_er_q <= 1'b0;
      lb_d_q  <= '0;
    end else if (loop) begin
      lb_en_q <= mac_tx_en;
      lb_er_q <= mac_tx_er;
      lb_d_q  <= mac_txd;
    end
  end

  always_comb begin
    line_tx_en = 1'b0;
    line_tx_er = 1'b0;
    line_txd   = '0;
    mac_rx_dv  = 1'b0;
    mac_rx_er  = 1'b0;
    mac_rxd    = '0;
    mac_crs    = 1'b0;
    mac_col    = 1'b0;
    if (path_on) begin
      if (loop) begin
        mac_rx_dv = lb_en_q;
        mac_rx_er = lb_er_q;
        mac_rxd   = lb_d_q;
        mac_crs   = lb_en_q;
      end else begin
        line_tx_en = mac_tx_en;
        line_tx_er = mac_tx_er;
        line_txd   = mac_txd;
        mac_rx_dv  = line_rx_dv;
        mac_rx_er  = line_rx_er;
        mac_rxd    = line_rxd;
        mac_crs    = line_crs;
        mac_col    = line_col;
      end
    end
  end

  assign mac_out_oe = ~iso;

  // R5: no collision is reported in loopback
  a_r5_no_col_loop: assert property (@(posedge clk) disable iff (!rst_n)
    loop |-> !mac_col);

  // R5: nothing goes to the medium in loopback
  a_r5_no_line_tx: assert property (@(posedge clk) disable iff (!rst_n)
    loop |-> (!line_tx_en && !line_tx_er));

  // R6: isolation blocks the transmit inputs
  a_r6_tx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    iso |-> (!line_tx_en && !line_tx_er && line_txd == '0));

endmodule

// File: rtl/phy_port_ctrl.sv
module phy_port_ctrl
  import phy_ctl_pkg::*;
#(
  parameter int RST_CYCLES  = 32500,
  parameter int BUSY_CYCLES = 3,
  parameter int WAKE_CYCLES = 12500000,
  parameter int DW          = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_wr_en,
  input  logic [WORD_W-1:0] mgmt_wr_data,
  output logic [WORD_W-1:0] mgmt_rd_data,
  output logic              mgmt_busy,
  input  logic              an_speed_100,
  input  logic              an_full_duplex,
  output logic              link_speed_100,
  output logic              link_full_duplex,
  output logic              loopback_on,
  output logic              powered_down,
  output logic              isolated,
  output logic              not_ready,
  input  logic              mac_tx_en,
  input  logic              mac_tx_er,
  input  logic [DW-1:0]     mac_txd,
  output logic              line_tx_en,
  output logic              line_tx_er,
  output logic [DW-1:0]     line_txd,
  input  logic              line_rx_dv,
  input  logic              line_rx_er,
  input  logic [DW-1:0]     line_rxd,
  input  logic              line_crs,
  input  logic              line_col,
  output logic              mac_rx_dv,
  output logic              mac_rx_er,
  output logic [DW-1:0]     mac_rxd,
  output logic              mac_crs,
  output logic              mac_col,
  output logic              mac_out_oe
);

  logic  rst_meta_q, rst_core_n;
  ctrl_t ctrl;
  logic  rst_active;
  logic  sleep;
  logic  path_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  phy_ctl_regs #(
    .RST_CYCLES (RST_CYCLES),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (mgmt_wr_en),
    .wr_data   (mgmt_wr_data),
    .ctrl      (ctrl),
    .rst_active(rst_active),
    .mgmt_busy (mgmt_busy)
  );

  assign sleep = ctrl.pdwn | ctrl.iso;

  phy_ctl_wake #(
    .WAKE_CYCLES(WAKE_CYCLES)
  ) i_wake (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sleep    (sleep),
    .not_ready(not_ready)
  );

  assign path_on = ~sleep & ~not_ready & ~rst_active;

  phy_ctl_datapath #(
    .DW(DW)
  ) i_path (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .loop      (ctrl.loop),
    .iso       (ctrl.iso),
    .path_on   (path_on),
    .mac_tx_en (mac_tx_en),
    .mac_tx_er (mac_tx_er),
    .mac_txd   (mac_txd),
    .line_tx_en(line_tx_en),
    .line_tx_er(line_tx_er),
    .line_txd  (line_txd),
    .line_rx_dv(line_rx_dv),
    .line_rx_er(line_rx_er),
    .line_rxd  (line_rxd),
    .line_crs  (line_crs),
    .line_col  (line_col),
    .mac_rx_dv (mac_rx_dv),
    .mac_rx_er (mac_rx_er),
    .mac_rxd   (mac_rxd),
    .mac_crs   (mac_crs),
    .mac_col   (mac_col),
    .mac_out_oe(mac_out_oe)
  );

  assign link_speed_100   = ctrl.an_en ? an_speed_100   : ctrl.speed;
  assign link_full_duplex = ctrl.an_en ? an_full_duplex : ctrl.duplex;
  assign loopback_on      = ctrl.loop;
  assign powered_down     = ctrl.pdwn;
  assign isolated         = ctrl.iso;
  assign mgmt_rd_data     = ctrl_to_word(ctrl, rst_active);

  // R7: power-down cuts the medium side but keeps pads driven
  a_r7_pdwn_gates: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctrl.pdwn && !ctrl.iso) |-> (mac_out_oe && !line_tx_en && !mac_rx_dv));

endmodule

// File: tb/test_phy_port_ctrl.sv
module test_phy_port_ctrl;

  localparam int RST  = 16;
  localparam int BUSY = 3;
  localparam int WAKE = 20;

  localparam int S_RD = 0, S_SPD = 1, S_DUP = 2, S_BUSY = 3, S_NRDY = 4,
                 S_LTXEN = 5, S_MRXD = 6, S_MRXDV = 7, S_MCOL = 8,
                 S_OE = 9, S_LTXD = 10, S_MCRS = 11, S_LOOP = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mgmt_wr_en;
  logic [15:0] mgmt_wr_data, mgmt_rd_data;
  logic        mgmt_busy, an_speed_100, an_full_duplex;
  logic        link_speed_100, link_full_duplex;
  logic        loopback_on, powered_down, isolated, not_ready;
  logic        mac_tx_en, mac_tx_er;
  logic [3:0]  mac_txd;
  logic        line_tx_en, line_tx_er;
  logic [3:0]  line_txd;
  logic        line_rx_dv, line_rx_er, line_crs, line_col;
  logic [3:0]  line_rxd;
  logic        mac_rx_dv, mac_rx_er, mac_crs, mac_col, mac_out_oe;
  logic [3:0]  mac_rxd;

  always #2 clk = ~clk;

  phy_port_ctrl #(.RST_CYCLES(RST), .BUSY_CYCLES(BUSY), .WAKE_CYCLES(WAKE)) i_phy_port_ctrl (
    .clk(clk), .rst_n(rst_n), .mgmt_wr_en(mgmt_wr_en), .mgmt_wr_data(mgmt_wr_data),
    .mgmt_rd_data(mgmt_rd_data), .mgmt_busy(mgmt_busy),
    .an_speed_100(an_speed_100), .an_full_duplex(an_full_duplex),
    .link_speed_100(link_speed_100), .link_full_duplex(link_full_duplex),
    .loopback_on(loopback_on), .powered_down(powered_down), .isolated(isolated),
    .not_ready(not_ready), .mac_tx_en(mac_tx_en), .mac_tx_er(mac_tx_er), .mac_txd(mac_txd),
    .line_tx_en(line_tx_en), .line_tx_er(line_tx_er), .line_txd(line_txd),
    .line_rx_dv(line_rx_dv), .line_rx_er(line_rx_er), .line_rxd(line_rxd),
    .line_crs(line_crs), .line_col(line_col), .mac_rx_dv(mac_rx_dv), .mac_rx_er(mac_rx_er),
    .mac_rxd(mac_rxd), .mac_crs(mac_crs), .mac_col(mac_col), .mac_out_oe(mac_out_oe)
  );

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  function automatic logic [15:0] observe(int sel);
    case (sel)
      S_RD:    return mgmt_rd_data;
      S_SPD:   return {15'd0, link_speed_100};
      S_DUP:   return {15'd0, link_full_duplex};
      S_BUSY:  return {15'd0, mgmt_busy};
      S_NRDY:  return {15'd0, not_ready};
      S_LTXEN: return {15'd0, line_tx_en};
      S_MRXD:  return {12'd0, mac_rxd};
      S_MRXDV: return {15'd0, mac_rx_dv};
      S_MCOL:  return {15'd0, mac_col};
      S_OE:    return {15'd0, mac_out_oe};
      S_LTXD:  return {12'd0, line_txd};
      S_MCRS:  return {15'd0, mac_crs};
      S_LOOP:  return {15'd0, loopback_on};
      default: return 16'hxxxx;
    endcase
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int sel, logic [15:0] exp, string req);
    q.push_back('{sel: sel, exp: exp, req: req});
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] v);
    mgmt_wr_en   = 1'b1;
    mgmt_wr_data = v;
    @(negedge clk);
    mgmt_wr_en   = 1'b0;
    mgmt_wr_data = 16'h0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mgmt_wr_en = 1'b0; mgmt_wr_data = '0;
    an_speed_100 = 1'b0; an_full_duplex = 1'b1;
    mac_tx_en = 1'b0; mac_tx_er = 1'b0; mac_txd = '0;
    line_rx_dv = 1'b0; line_rx_er = 1'b0; line_rxd = '0; line_crs = 1'b0; line_col = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R1: reset state
    expect_val(S_RD, 16'h3000, "R1");
    expect_val(S_BUSY, 0, "R1");
    expect_val(S_NRDY, 0, "R1");
    expect_val(S_OE, 1, "R1");
    // R4: auto-negotiation on, result inputs drive the link
    expect_val(S_SPD, 0, "R4");
    expect_val(S_DUP, 1, "R4");
    step(1);

    // R4: manual selection
    wr(16'h0000);
    expect_val(S_RD, 16'h0000, "R4");
    expect_val(S_SPD, 0, "R4");
    expect_val(S_DUP, 0, "R4");
    wr(16'h2100);
    expect_val(S_SPD, 1, "R4");
    expect_val(S_DUP, 1, "R4");
    // R4: bits stay readable but are bypassed under auto-negotiation
    an_speed_100 = 1'b0; an_full_duplex = 1'b0;
    wr(16'h3100);
    expect_val(S_RD, 16'h3100, "R4");
    expect_val(S_SPD, 0, "R4");
    expect_val(S_DUP, 0, "R4");

    // R9: normal pass-through
    wr(16'h3000);
    mac_tx_en = 1'b1; mac_txd = 4'h5; line_rxd = 4'hA; line_rx_dv = 1'b1; line_col = 1'b1;
    #1;
    expect_val(S_LTXEN, 1, "R9");
    expect_val(S_LTXD, 16'h5, "R9");
    expect_val(S_MRXD, 16'hA, "R9");
    expect_val(S_MCOL, 1, "R9");
    step(1);

    // R5: loopback
    wr(16'h7000);
    step(1);
    expect_val(S_MRXD, 16'h5, "R5");
    expect_val(S_MRXDV, 1, "R5");
    expect_val(S_MCRS, 1, "R5");
    expect_val(S_MCOL, 0, "R5");
    expect_val(S_LTXEN, 0, "R5");
    mac_txd = 4'h9;
    step(1);
    expect_val(S_MRXD, 16'h9, "R5");
    expect_val(S_LTXD, 16'h0, "R5");

    // R6: isolate
    wr(16'h3400);
    expect_val(S_RD, 16'h3400, "R6");
    expect_val(S_OE, 0, "R6");
    expect_val(S_LTXEN, 0, "R6");
    expect_val(S_MRXD, 16'h0, "R6");
    // R8: wake-up window after leaving isolate
    wr(16'h3000);
    expect_val(S_NRDY, 1, "R8");
    expect_val(S_LTXEN, 0, "R8");
    expect_val(S_OE, 1, "R8");
    step(WAKE - 1);
    expect_val(S_NRDY, 1, "R8");
    step(1);
    expect_val(S_NRDY, 0, "R8");
    expect_val(S_LTXEN, 1, "R8");

    // R7: power-down keeps stored bits
    wr(16'h0900);
    expect_val(S_RD, 16'h0900, "R7");
    expect_val(S_LTXEN, 0, "R7");
    expect_val(S_MRXD, 16'h0, "R7");
    expect_val(S_OE, 1, "R7");
    expect_val(S_DUP, 1, "R7");
    wr(16'h0100);
    step(WAKE);
    expect_val(S_NRDY, 0, "R7");
    expect_val(S_LTXEN, 1, "R7");
    expect_val(S_DUP, 1, "R7");
    expect_val(S_SPD, 0, "R7");

    // R2: reset with other bits set discards them
    wr(16'hC100);
    expect_val(S_RD, 16'hB000, "R2");
    expect_val(S_LOOP, 0, "R2");
    expect_val(S_LTXEN, 0, "R2");
    // R2: write during reset is ignored
    wr(16'h4000);
    expect_val(S_RD, 16'hB000, "R2");
    step(RST - 2);
    // R3: reset bit still set on the last cycle
    expect_val(S_RD, 16'hB000, "R3");
    expect_val(S_BUSY, 0, "R3");
    // R2/R3: write on the final reset edge is ignored, busy opens
    wr(16'h0100);
    expect_val(S_RD, 16'h3000, "R3");
    expect_val(S_BUSY, 1, "R3");
    // R2: write inside busy window is stored
    wr(16'h0100);
    expect_val(S_RD, 16'h0100, "R2");
    expect_val(S_BUSY, 1, "R3");
    step(1);
    expect_val(S_BUSY, 1, "R3");
    step(1);
    expect_val(S_BUSY, 0, "R3");

    // R1: hardware reset restores defaults
    wr(16'h7800);
    rst_n = 1'b0;
    expect_val(S_RD, 16'h3000, "R1");
    step(2);
    rst_n = 1'b1;
    step(3);
    expect_val(S_RD, 16'h3000, "R1");
    expect_val(S_NRDY, 0, "R1");
    step(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule